// File: doc/BRIEF.md
# Two-Input Dataflow Actor Controller

This block wraps a fixed-latency computation as a dataflow actor. It has two input token ports and one output token port, and every port moves tokens with a strobe and acknowledge pair. The computation inside is a placeholder: the output token carries the sum of the two input tokens, wrapped to the data width.

One latency parameter and one scheduling parameter give two kinds of actor. A sequential actor takes one pair of tokens and works on it for the latency. It then offers the result and accepts nothing new until that result has been taken. A pipelined actor can take a new pair on every cycle and offers each result the latency number of cycles after it took the inputs. If the consumer refuses a result, the whole pipeline freezes until the result is taken.

The actor is meant to sit between other actors of the same handshake. Any producer that holds its strobe until acknowledged, and any consumer that raises acknowledge when ready, can connect to it directly.

Top module: `df_actor_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after reset, out_stb is low.
- R2: A token moves on a port only in a cycle where that port's strobe and acknowledge are both high. in0_ack and in1_ack are always equal, and they are high only when in0_stb and in1_stb are both high. A strobe on one input alone is ignored: nothing is accepted and no output token results.
- R3: In sequential mode (SCHED = SCHED_SEQ) the inputs are acknowledged only while no token is in flight and no output is waiting to be taken.
- R4: In sequential mode the result of a pair accepted in cycle t is offered on out_stb from cycle t+LATENCY.
- R5: In pipelined mode (SCHED = SCHED_PIPE) a pair with both strobes high is acknowledged in every cycle in which the output is not stalled.
- R6: In pipelined mode the result of a pair accepted in cycle t is offered in cycle t+LATENCY plus the number of stalled cycles in between, and results leave in acceptance order.
- R7: In pipelined mode, a cycle with out_stb high and out_ack low is a stall. During a stall the input acknowledges are low and no stage moves.
- R8: Once out_stb is high it stays high, with out_data unchanged, until the cycle in which out_ack is high.
- R9: out_data equals (in0_data + in1_data) modulo 2^DATA_W, taken from the pair that produced the token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in0_stb | input | 1 | Token present on input 0 |
| in0_data | input | DATA_W | Input 0 token value |
| in0_ack | output | 1 | Input 0 token taken this cycle |
| in1_stb | input | 1 | Token present on input 1 |
| in1_data | input | DATA_W | Input 1 token value |
| in1_ack | output | 1 | Input 1 token taken this cycle |
| out_stb | output | 1 | Result token offered |
| out_data | output | DATA_W | Result token value |
| out_ack | input | 1 | Consumer takes the result this cycle |

## Verification
The hardest situation to reach is a pipelined stall with tokens spread over several stages and bubbles between them. If that goes wrong, a frozen stage can drop or duplicate a token. To reach it, the stimulus streams pairs into a full pipeline while the consumer acknowledges in an irregular pattern, with long refusal runs. Only one input is strobed at times, which leaves bubbles. A bench model keeps a list of in-flight tokens with ages and predicts the acknowledges and the output on every cycle. Three variants run on the same stimulus: sequential with latency 3, pipelined with latency 3 and pipelined with latency 1.

// File: rtl/df_actor_pkg.sv
package df_actor_pkg;
  typedef enum logic {
    SCHED_SEQ  = 1'b0,
    SCHED_PIPE = 1'b1
  } sched_e;

  function automatic int cnt_width(input int lat);
    return (lat < 2) ? 1 : $clog2(lat + 1);
  endfunction
endpackage

// File: rtl/df_join.sv
// Joins the two input strobes; fires only when both are present and the
// controller is ready.
module df_join (
  input  logic clk,
  input  logic rst,
  input  logic in0_stb,
  input  logic in1_stb,
  input  logic ready,
  output logic fire,
  output logic in0_ack,
  output logic in1_ack
);
  always_comb begin
    fire    = ready && in0_stb && in1_stb;
    in0_ack = fire;
    in1_ack = fire;
  end

  // R2: acknowledge only with both strobes present
  a_r2_ack_needs_both: assert property (@(posedge clk) disable iff (rst)
    (in0_ack || in1_ack) |-> (in0_stb && in1_stb));
endmodule

// File: rtl/df_seq_ctrl.sv
// Sequential schedule: one token set at a time, LATENCY cycles each.
module df_seq_ctrl #(
  parameter int DATA_W  = 16,
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [DATA_W-1:0] sum,
  input  logic              out_ack,
  output logic              ready,
  output logic              out_stb,
  output logic [DATA_W-1:0] out_data
);
  localparam int CNT_W = df_actor_pkg::cnt_width(LATENCY);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             out_v;
  logic [DATA_W-1:0] out_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      out_v <= 1'b0;
      out_d <= '0;
    end else begin
      if (out_v && out_ack) out_v <= 1'b0;
      if (busy) begin
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy  <= 1'b0;
          out_v <= 1'b1;
        end
      end
      if (fire) begin
        out_d <= sum;
        if (LATENCY == 1) begin
          out_v <= 1'b1;
        end else begin
          busy <= 1'b1;
          cnt  <= CNT_W'(LATENCY - 1);
        end
      end
    end
  end

  assign ready    = !busy && !out_v;
  assign out_stb  = out_v;
  assign out_data = out_d;

  // R3: no firing while work is in flight or a result waits
  a_r3_hold_off: assert property (@(posedge clk) disable iff (rst)
    (busy || out_v) |-> !fire);

  // R4: the result appears only at the end of the count
  a_r4_rise_after_count: assert property (@(posedge clk) disable iff (rst)
    $rose(out_v) |-> ($past(busy) && ($past(cnt) == CNT_W'(1))) ||
                     ((LATENCY == 1) && $past(fire)));
endmodule

// File: rtl/df_pipe_ctrl.sv
// Pipelined schedule: LATENCY stages of valid+data, frozen as a whole when
// the output is refused.
module df_pipe_ctrl #(
  parameter int DATA_W  = 16,
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [DATA_W-1:0] sum,
  input  logic              out_ack,
  output logic              ready,
  output logic              out_stb,
  output logic [DATA_W-1:0] out_data
);
  localparam int LAST = LATENCY - 1;

  logic [LATENCY-1:0] vld;
  logic [DATA_W-1:0]  dat [LATENCY];
  logic               advance;

  assign advance = !(vld[LAST] && !out_ack);

  always_ff @(posedge clk) begin
    if (rst) vld[0] <= 1'b0;
    else if (advance) vld[0] <= fire;
  end

  always_ff @(posedge clk) begin
    if (advance) dat[0] <= sum;
  end

  for (genvar i = 1; i < LATENCY; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) vld[i] <= 1'b0;
      else if (advance) vld[i] <= vld[i-1];
    end
    always_ff @(posedge clk) begin
      if (advance) dat[i] <= dat[i-1];
    end
  end

  assign ready    = advance;
  assign out_stb  = vld[LAST];
  assign out_data = dat[LAST];

  // R7: a refused output blocks input acceptance
  a_r7_no_accept: assert property (@(posedge clk) disable iff (rst)
    (out_stb && !out_ack) |-> !fire);

  // R7: a refused output freezes every stage
  a_r7_freeze: assert property (@(posedge clk) disable iff (rst)
    (out_stb && !out_ack) |=> $stable(vld));
endmodule

// File: rtl/df_actor_ctrl.sv
module df_actor_ctrl #(
  parameter int                   DATA_W  = 16,
  parameter int                   LATENCY = 3,
  parameter df_actor_pkg::sched_e SCHED   = df_actor_pkg::SCHED_SEQ
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in0_stb,
  input  logic [DATA_W-1:0] in0_data,
  output logic              in0_ack,
  input  logic              in1_stb,
  input  logic [DATA_W-1:0] in1_data,
  output logic              in1_ack,
  output logic              out_stb,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ack
);
  logic              ready;
  logic              fire;
  logic [DATA_W-1:0] sum;

  assign sum = in0_data + in1_data;

  df_join u_join (
    .clk     (clk),
    .rst     (rst),
    .in0_stb (in0_stb),
    .in1_stb (in1_stb),
    .ready   (ready),
    .fire    (fire),
    .in0_ack (in0_ack),
    .in1_ack (in1_ack)
  );

  if (SCHED == df_actor_pkg::SCHED_PIPE) begin : g_pipe
    df_pipe_ctrl #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_ctrl (
      .clk(clk), .rst(rst), .fire(fire), .sum(sum), .out_ack(out_ack),
      .ready(ready), .out_stb(out_stb), .out_data(out_data)
    );
  end else begin : g_seq
    df_seq_ctrl #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_ctrl (
      .clk(clk), .rst(rst), .fire(fire), .sum(sum), .out_ack(out_ack),
      .ready(ready), .out_stb(out_stb), .out_data(out_data)
    );
  end

  // R8: an offered result holds until taken
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (out_stb && !out_ack) |=> (out_stb && $stable(out_data)));

  // R1: no output in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> !out_stb);
endmodule

// File: tb/df_actor_ctrl_test.sv
module df_actor_ctrl_test;
  localparam int W    = 8;
  localparam int NI   = 3;
  localparam int SLOT = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_stb = 1'b0, b_stb = 1'b0, y_ack = 1'b0;
  logic [W-1:0] a_dat = '0, b_dat = '0;

  logic         ack0 [NI];
  logic         ack1 [NI];
  logic         ystb [NI];
  logic [W-1:0] ydat [NI];

  always #4 clk = ~clk;

  df_actor_ctrl #(.DATA_W(W), .LATENCY(3), .SCHED(df_actor_pkg::SCHED_SEQ)) uut (
    .clk(clk), .rst(rst), .in0_stb(a_stb), .in0_data(a_dat), .in0_ack(ack0[0]),
    .in1_stb(b_stb), .in1_data(b_dat), .in1_ack(ack1[0]),
    .out_stb(ystb[0]), .out_data(ydat[0]), .out_ack(y_ack));

  df_actor_ctrl #(.DATA_W(W), .LATENCY(3), .SCHED(df_actor_pkg::SCHED_PIPE)) uut_pipe (
    .clk(clk), .rst(rst), .in0_stb(a_stb), .in0_data(a_dat), .in0_ack(ack0[1]),
    .in1_stb(b_stb), .in1_data(b_dat), .in1_ack(ack1[1]),
    .out_stb(ystb[1]), .out_data(ydat[1]), .out_ack(y_ack));

  df_actor_ctrl #(.DATA_W(W), .LATENCY(1), .SCHED(df_actor_pkg::SCHED_PIPE)) uut_pipe1 (
    .clk(clk), .rst(rst), .in0_stb(a_stb), .in0_data(a_dat), .in0_ack(ack0[2]),
    .in1_stb(b_stb), .in1_data(b_dat), .in1_ack(ack1[2]),
    .out_stb(ystb[2]), .out_data(ydat[2]), .out_ack(y_ack));

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;
  int  cyc    = 0;

  // reference model state
  int  lat   [NI] = '{3, 3, 1};
  bit  pipe  [NI] = '{1'b0, 1'b1, 1'b1};
  int  scnt  [NI];
  bit  sov   [NI];
  int  sod   [NI];
  bit  tv    [NI][SLOT];
  int  tage  [NI][SLOT];
  int  tval  [NI][SLOT];

  task automatic chk(input bit ok, input string tag, input int k,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s inst %0d cycle %0d: actual %0d expected %0d",
               tag, k, cyc, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < NI; k++) begin
      scnt[k] = 0; sov[k] = 0; sod[k] = 0;
      for (int s = 0; s < SLOT; s++) begin
        tv[k][s] = 0; tage[k][s] = 0; tval[k][s] = 0;
      end
    end
  endtask

  // One cycle: drive at the falling edge, compare, then advance the model.
  task automatic cycle(input bit as, input bit bs, input int ad, input int bd,
                       input bit ya);
    @(negedge clk);
    a_stb = as; b_stb = bs; a_dat = W'(ad); b_dat = W'(bd); y_ack = ya;
    #1;
    cyc++;
    for (int k = 0; k < NI; k++) begin
      bit e_out; int e_dat; bit e_ack; bit stall; int oslot;
      int sum;
      sum = (ad + bd) % (1 << W);
      if (!pipe[k]) begin
        e_out = sov[k]; e_dat = sod[k];
        e_ack = (scnt[k] == 0) && !sov[k] && as && bs;
        chk(ack0[k] == e_ack, "R2/R3 in0_ack", k, int'(ack0[k]), int'(e_ack));
        chk(ack1[k] == e_ack, "R2/R3 in1_ack", k, int'(ack1[k]), int'(e_ack));
        chk(ystb[k] == e_out, "R4/R8 out_stb", k, int'(ystb[k]), int'(e_out));
        if (e_out) chk(int'(ydat[k]) == e_dat, "R4/R8/R9 out_data", k, int'(ydat[k]), e_dat);
        // advance
        if (sov[k] && ya) sov[k] = 0;
        if (scnt[k] > 0) begin
          scnt[k]--;
          if (scnt[k] == 0) sov[k] = 1;
        end
        if (e_ack) begin
          sod[k] = sum;
          if (lat[k] == 1) sov[k] = 1; else scnt[k] = lat[k] - 1;
        end
      end else begin
        oslot = -1;
        for (int s = 0; s < SLOT; s++)
          if (tv[k][s] && tage[k][s] == lat[k]) oslot = s;
        e_out = (oslot >= 0);
        e_dat = e_out ? tval[k][oslot] : 0;
        stall = e_out && !ya;
        e_ack = !stall && as && bs;
        chk(ack0[k] == e_ack, "R5/R7 in0_ack", k, int'(ack0[k]), int'(e_ack));
        chk(ack1[k] == e_ack, "R5/R7 in1_ack", k, int'(ack1[k]), int'(e_ack));
        chk(ystb[k] == e_out, "R6/R8 out_stb", k, int'(ystb[k]), int'(e_out));
        if (e_out) chk(int'(ydat[k]) == e_dat, "R6/R8/R9 out_data", k, int'(ydat[k]), e_dat);
        if (!stall) begin
          if (oslot >= 0) tv[k][oslot] = 0;
          for (int s = 0; s < SLOT; s++) if (tv[k][s]) tage[k][s]++;
          if (e_ack) begin
            for (int s = 0; s < SLOT; s++) begin
              if (!tv[k][s] && e_ack) begin
                tv[k][s] = 1; tage[k][s] = 1; tval[k][s] = sum; e_ack = 0;
              end
            end
          end
        end
      end
    end
  endtask

  initial begin
    model_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < NI; k++)
      chk(ystb[k] == 1'b0, "R1 out_stb in reset", k, int'(ystb[k]), 0);
    rst = 1'b0;
    // first cycle after reset: R1 checked by the model (no token yet)
    cycle(0, 0, 0, 0, 1);
    for (int k = 0; k < NI; k++)
      chk(ystb[k] == 1'b0, "R1 out_stb after reset", k, int'(ystb[k]), 0);

    // R5: streaming, consumer always ready
    for (int i = 0; i < 20; i++) cycle(1, 1, i, 3 * i, 1);
    // R7: irregular refusals on a full stream
    for (int i = 0; i < 24; i++) cycle(1, 1, 7 * i, i + 1, (i % 3) != 0);
    // R8: long refusal run
    for (int i = 0; i < 10; i++) cycle(1, 1, i, i, 0);
    for (int i = 0; i < 4; i++) cycle(0, 0, 0, 0, 1);
    // R2: one input alone is ignored
    for (int i = 0; i < 8; i++) cycle(1, 0, 5, 6, 1);
    for (int i = 0; i < 8; i++) cycle(0, 1, 5, 6, 1);
    // R9: wraparound sum 0xFF + 0x03 = 0x02
    cycle(1, 1, 255, 3, 1);
    for (int i = 0; i < 6; i++) cycle(0, 0, 0, 0, 1);
    // mixed traffic
    for (int i = 0; i < 400; i++)
      cycle(($urandom % 4) != 0, ($urandom % 4) != 0, $urandom % 256,
            $urandom % 256, ($urandom % 3) != 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule